// File: doc/BRIEF.md
# Audio Baud-Rate Clock Generator

This block produces the bit-clock timing for a group of serial audio channels from four audio reference clocks. Two independent fractional-free dividers are provided: divider A is meant for rates in the 44.1 kHz family and divider B for the 48 kHz family. Each divider takes its input from a selectable reference. That input passes through a first stage, a power-of-four prescaler, and then through a second-stage counter of programmable length. The divider emits a single-cycle tick each time the second stage wraps.

Everything runs in one system clock domain. Each reference clock arrives as a clock-enable strobe, and each output is a strobe of the same kind. A control write chooses the reference for each divider and chooses which divider drives the shared clock-out strobe. Routing registers give every serial channel an 8-bit code. The code connects the channel to one of three raw references or to one of the two divided ticks, or stops the channel. Registers are loaded through plain write-enable ports.

Top module: `audio_brg`

## Requirements
- R1: After reset both dividers are set to prescale code 0 with count 2, which divides by 6. Both take reference A (source code 0). The clock-out strobe follows divider A, every routing code is 0x00, and no output is active.
- R2: A divider word is 10 bits: bits 9:8 are the prescale code p and bits 7:0 are the count N. Between successive ticks the divider counts exactly (2<<(2p))·(N+1) strobes of its selected reference, which gives a prescale of 2, 8, 32 or 128.
- R3: A tick lasts one system-clock cycle. It appears in the cycle after the reference strobe that completes the period, and it is never high in two consecutive cycles.
- R4: Source codes are 0 for reference A (ref_stb[0]), 1 for reference B (ref_stb[1]), 4 for reference C (ref_stb[2]) and 2 for the internal reference (ref_stb[3]). Any other code leaves the divider without input, and it produces no ticks.
- R5: When the output select is 1, clkout_tick equals tick_b. When it is 0, clkout_tick equals tick_a.
- R6: Channel routing codes: 0x01, 0x02 and 0x03 pass ref_stb[0], ref_stb[1] and ref_stb[2] in the same cycle. 0x10 passes tick_a and 0x20 passes tick_b. 0x00 and every other code hold the channel low.
- R7: Channel c takes its code from routing register c/4, in byte lane c mod 4, which is bits 8·(c mod 4)+7 down to 8·(c mod 4).
- R8: Writing a divider word clears both counter stages and any pending tick. The next tick follows only after a full new period of strobes counted from the write.
- R9: A divider whose reference never strobes emits no ticks, and the other divider keeps ticking at its own period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_stb | input | 4 | Reference strobes: [0] ref A, [1] ref B, [2] ref C, [3] internal |
| ctl_we | input | 1 | Load the control fields |
| ctl_src_a | input | 3 | Source code for divider A |
| ctl_src_b | input | 3 | Source code for divider B |
| ctl_out_b | input | 1 | 1: clock-out follows divider B; 0: divider A |
| div_a_we | input | 1 | Load divider A word from div_wdata |
| div_b_we | input | 1 | Load divider B word from div_wdata |
| div_wdata | input | 10 | Divider word: [9:8] prescale code, [7:0] count N |
| route_we | input | 1 | Load a routing register |
| route_sel | input | RSEL_W | Index of the routing register to load |
| route_wdata | input | 32 | Four 8-bit channel codes, lane n in bits 8n+7:8n |
| tick_a | output | 1 | Divider A tick |
| tick_b | output | 1 | Divider B tick |
| clkout_tick | output | 1 | Shared clock-out tick |
| chan_clk | output | NUM_CH | Per-channel clock strobe |

## Verification
The bench targets the exact tick spacing at the smallest and largest prescale codes. An off-by-one in either stage would show up there as ticks that drift by a strobe every period. A rewrite in the middle of a period checks the restart rule. A design that kept its counters would tick early after the write. The bench also feeds the out-of-order source codes, an unused source code and routing codes that are not defined. A divider wired to the wrong reference would tick with no strobe present, or stay silent when one is, and a channel with a bad decode would pass strobes it should block. With only one reference strobing, the bench confirms that the other divider stays idle and does not hold back its neighbour.

// File: rtl/abrg_pkg.sv
`timescale 1ns/1ps
package abrg_pkg;

    localparam int NUM_REF   = 4;
    localparam int PRE_W     = 2;
    localparam int CNT_W     = 8;
    localparam int DIV_W     = PRE_W + CNT_W;
    localparam int SRC_W     = 3;
    localparam int CODE_W    = 8;
    localparam int LANES     = 4;
    localparam int STAGE1_W  = 7;

    typedef enum logic [1:0] {
        REF_A   = 2'd0,
        REF_B   = 2'd1,
        REF_C   = 2'd2,
        REF_INT = 2'd3
    } ref_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } div_cfg_t;

    localparam div_cfg_t DIV_RESET = '{pre: 2'd0, cnt: 8'd2};

    typedef struct packed {
        logic             out_b;
        logic [SRC_W-1:0] src_a;
        logic [SRC_W-1:0] src_b;
    } ctl_t;

    localparam logic [CODE_W-1:0] RT_REF_A = 8'h01;
    localparam logic [CODE_W-1:0] RT_REF_B = 8'h02;
    localparam logic [CODE_W-1:0] RT_REF_C = 8'h03;
    localparam logic [CODE_W-1:0] RT_DIV_A = 8'h10;
    localparam logic [CODE_W-1:0] RT_DIV_B = 8'h20;

    // Non-sequential source encoding: returns a one-hot reference mask.
    function automatic logic [NUM_REF-1:0] src_decode(input logic [SRC_W-1:0] code);
        logic [NUM_REF-1:0] m;
        m = '0;
        case (code)
            3'd0: m[REF_A]   = 1'b1;
            3'd1: m[REF_B]   = 1'b1;
            3'd4: m[REF_C]   = 1'b1;
            3'd2: m[REF_INT] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

    // Terminal value of the first stage: (2 << 2p) - 1.
    function automatic logic [STAGE1_W-1:0] pre_last(input logic [PRE_W-1:0] p);
        logic [STAGE1_W:0] ratio;
        ratio = (STAGE1_W+1)'(2) << {p, 1'b0};
        return STAGE1_W'(ratio - 1'b1);
    endfunction

endpackage

// File: rtl/abrg_divider.sv
`timescale 1ns/1ps
module abrg_divider
    import abrg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stb_in,
    input  logic     cfg_we,
    input  div_cfg_t cfg_wdata,
    output logic     tick
);

    div_cfg_t              cfg_q;
    logic [STAGE1_W-1:0]   s1_q;
    logic [CNT_W-1:0]      s2_q;
    logic                  s1_wrap;
    logic                  s2_wrap;

    assign s1_wrap = stb_in && (s1_q == pre_last(cfg_q.pre));
    assign s2_wrap = s1_wrap && (s2_q == cfg_q.cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= DIV_RESET;
            s1_q  <= '0;
            s2_q  <= '0;
            tick  <= 1'b0;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
            s1_q  <= '0;
            s2_q  <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= s2_wrap;
            if (stb_in) begin
                if (s1_wrap) begin
                    s1_q <= '0;
                    s2_q <= s2_wrap ? '0 : s2_q + 1'b1;
                end else begin
                    s1_q <= s1_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/abrg_chan_mux.sv
`timescale 1ns/1ps
module abrg_chan_mux
    import abrg_pkg::*;
(
    input  logic [CODE_W-1:0]  code,
    input  logic [NUM_REF-1:0] ref_stb,
    input  logic               tick_a,
    input  logic               tick_b,
    output logic               chan_out
);

    always_comb begin
        case (code)
            RT_REF_A: chan_out = ref_stb[REF_A];
            RT_REF_B: chan_out = ref_stb[REF_B];
            RT_REF_C: chan_out = ref_stb[REF_C];
            RT_DIV_A: chan_out = tick_a;
            RT_DIV_B: chan_out = tick_b;
            default:  chan_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/audio_brg.sv
`timescale 1ns/1ps
module audio_brg
    import abrg_pkg::*;
#(
    parameter  int NUM_ROUTE_REGS = 2,
    localparam int NUM_CH = NUM_ROUTE_REGS * LANES,
    localparam int RSEL_W = (NUM_ROUTE_REGS > 1) ? $clog2(NUM_ROUTE_REGS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_REF-1:0]      ref_stb,
    input  logic                    ctl_we,
    input  logic [SRC_W-1:0]        ctl_src_a,
    input  logic [SRC_W-1:0]        ctl_src_b,
    input  logic                    ctl_out_b,
    input  logic                    div_a_we,
    input  logic                    div_b_we,
    input  logic [DIV_W-1:0]        div_wdata,
    input  logic                    route_we,
    input  logic [RSEL_W-1:0]       route_sel,
    input  logic [CODE_W*LANES-1:0] route_wdata,
    output logic                    tick_a,
    output logic                    tick_b,
    output logic                    clkout_tick,
    output logic [NUM_CH-1:0]       chan_clk
);

    localparam int NUM_DIV = 2;

    ctl_t                    ctl_q;
    logic [CODE_W*LANES-1:0] route_q [NUM_ROUTE_REGS];
    logic [NUM_DIV-1:0]      div_we_v;
    logic [SRC_W-1:0]        src_code_v [NUM_DIV];
    logic [NUM_DIV-1:0]      tick_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= '{out_b: ctl_out_b, src_a: ctl_src_a, src_b: ctl_src_b};
        end
    end

    for (genvar r = 0; r < NUM_ROUTE_REGS; r++) begin : g_route
        always_ff @(posedge clk) begin
            if (rst) begin
                route_q[r] <= '0;
            end else if (route_we && (int'(route_sel) == r)) begin
                route_q[r] <= route_wdata;
            end
        end
    end

    assign div_we_v      = {div_b_we, div_a_we};
    assign src_code_v[0] = ctl_q.src_a;
    assign src_code_v[1] = ctl_q.src_b;

    for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
        logic src_stb;
        assign src_stb = |(src_decode(src_code_v[d]) & ref_stb);

        abrg_divider u_div (
            .clk       (clk),
            .rst       (rst),
            .stb_in    (src_stb),
            .cfg_we    (div_we_v[d]),
            .cfg_wdata (div_cfg_t'(div_wdata)),
            .tick      (tick_v[d])
        );
    end

    assign tick_a      = tick_v[0];
    assign tick_b      = tick_v[1];
    assign clkout_tick = ctl_q.out_b ? tick_v[1] : tick_v[0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        abrg_chan_mux u_mux (
            .code     (route_q[c / LANES][CODE_W*(c % LANES) +: CODE_W]),
            .ref_stb  (ref_stb),
            .tick_a   (tick_v[0]),
            .tick_b   (tick_v[1]),
            .chan_out (chan_clk[c])
        );
    end

endmodule

// File: rtl/audio_brg_chk.sv
`timescale 1ns/1ps
module audio_brg_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        ref_stb,
    input logic              div_a_we,
    input logic              div_b_we,
    input logic              tick_a,
    input logic              tick_b,
    input logic              clkout_tick,
    input logic [NUM_CH-1:0] chan_clk
);

    // R3: a tick never lasts two cycles
    a_r3_single_a: assert property (@(posedge clk) disable iff (rst)
        tick_a |=> !tick_a);
    a_r3_single_b: assert property (@(posedge clk) disable iff (rst)
        tick_b |=> !tick_b);

    // R8: a divider write clears the pending tick
    a_r8_restart_a: assert property (@(posedge clk) disable iff (rst)
        div_a_we |=> !tick_a);
    a_r8_restart_b: assert property (@(posedge clk) disable iff (rst)
        div_b_we |=> !tick_b);

    // R9: no reference strobe, no tick in the following cycle
    a_r9_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        !(|ref_stb) |=> (!tick_a && !tick_b));

    // R5: clock-out only pulses when a divider ticks
    a_r5_clkout_src: assert property (@(posedge clk) disable iff (rst)
        clkout_tick |-> (tick_a || tick_b));

    // R6: a channel pulse always has a live source
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        a_r6_chan_src: assert property (@(posedge clk) disable iff (rst)
            chan_clk[c] |-> ((|ref_stb) || tick_a || tick_b));
    end

endmodule

bind audio_brg audio_brg_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_stb     (ref_stb),
    .div_a_we    (div_a_we),
    .div_b_we    (div_b_we),
    .tick_a      (tick_a),
    .tick_b      (tick_b),
    .clkout_tick (clkout_tick),
    .chan_clk    (chan_clk)
);

// File: tb/audio_brg_bench.sv
`timescale 1ns/1ps
module audio_brg_bench;

    localparam int NRR = 2;
    localparam int NCH = NRR * 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [3:0]     ref_stb = '0;
    logic           ctl_we = 1'b0;
    logic [2:0]     ctl_src_a = '0;
    logic [2:0]     ctl_src_b = '0;
    logic           ctl_out_b = 1'b0;
    logic           div_a_we = 1'b0;
    logic           div_b_we = 1'b0;
    logic [9:0]     div_wdata = '0;
    logic           route_we = 1'b0;
    logic [0:0]     route_sel = '0;
    logic [31:0]    route_wdata = '0;
    logic           tick_a, tick_b, clkout_tick;
    logic [NCH-1:0] chan_clk;

    audio_brg #(.NUM_ROUTE_REGS(NRR)) u_audio_brg (
        .clk(clk), .rst(rst), .ref_stb(ref_stb),
        .ctl_we(ctl_we), .ctl_src_a(ctl_src_a), .ctl_src_b(ctl_src_b), .ctl_out_b(ctl_out_b),
        .div_a_we(div_a_we), .div_b_we(div_b_we), .div_wdata(div_wdata),
        .route_we(route_we), .route_sel(route_sel), .route_wdata(route_wdata),
        .tick_a(tick_a), .tick_b(tick_b), .clkout_tick(clkout_tick), .chan_clk(chan_clk)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mon_on = 0;

    // Reference model state
    int qa[$];
    int qb[$];
    int div_tot[2] = '{6, 6};
    int src_idx[2] = '{0, 0};
    int cnt[2] = '{0, 0};
    bit out_b_m = 0;
    logic [7:0] code_m[NCH];
    logic prev_a = 0, prev_b = 0;

    function automatic int src_of(input logic [2:0] code);
        case (code)
            3'd0: return 0;
            3'd1: return 1;
            3'd4: return 2;
            3'd2: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: one cycle of strobes; pushes expected tick cycles
    task automatic pulse(input logic [3:0] mask);
        @(posedge clk); #1;
        ref_stb = mask;
        for (int d = 0; d < 2; d++) begin
            if (src_idx[d] >= 0 && mask[src_idx[d]]) begin
                cnt[d]++;
                if (cnt[d] == div_tot[d]) begin
                    cnt[d] = 0;
                    if (d == 0) qa.push_back(cyc + 1);
                    else        qb.push_back(cyc + 1);
                end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            ref_stb = '0;
        end
    endtask

    task automatic wr_div(input int d, input logic [1:0] p, input logic [7:0] n);
        @(posedge clk); #1;
        ref_stb = '0;
        div_wdata = {p, n};
        div_a_we = (d == 0);
        div_b_we = (d == 1);
        div_tot[d] = (2 << (2 * p)) * (int'(n) + 1);
        cnt[d] = 0;
        @(posedge clk); #1;
        div_a_we = 0;
        div_b_we = 0;
    endtask

    task automatic wr_ctl(input logic [2:0] a, input logic [2:0] b, input bit o);
        @(posedge clk); #1;
        ref_stb = '0;
        ctl_we = 1; ctl_src_a = a; ctl_src_b = b; ctl_out_b = o;
        @(posedge clk); #1;
        ctl_we = 0;
        src_idx[0] = src_of(a);
        src_idx[1] = src_of(b);
        out_b_m = o;
    endtask

    task automatic wr_route(input int sel, input logic [31:0] w);
        @(posedge clk); #1;
        ref_stb = '0;
        route_we = 1; route_sel = sel[0:0]; route_wdata = w;
        @(posedge clk); #1;
        route_we = 0;
        for (int l = 0; l < 4; l++) code_m[sel * 4 + l] = w[8*l +: 8];
    endtask

    task automatic drain(input string req);
        idle(3);
        check(qa.size() == 0, req, qa.size(), 0);
        check(qb.size() == 0, req, qb.size(), 0);
        qa.delete();
        qb.delete();
    endtask

    // Monitor: scoreboard compare, away from the active edge
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (tick_a) begin
                if (qa.size() == 0) check(0, "R2 R9 A unexpected tick", 1, 0);
                else begin
                    int e;
                    e = qa.pop_front();
                    check(cyc == e, "R2 A tick cycle", cyc, e);
                end
            end else if (qa.size() != 0 && qa[0] <= cyc) begin
                check(0, "R2 A missing tick", cyc, qa[0]);
                void'(qa.pop_front());
            end
            if (tick_b) begin
                if (qb.size() == 0) check(0, "R2 R9 B unexpected tick", 1, 0);
                else begin
                    int e;
                    e = qb.pop_front();
                    check(cyc == e, "R2 B tick cycle", cyc, e);
                end
            end else if (qb.size() != 0 && qb[0] <= cyc) begin
                check(0, "R2 B missing tick", cyc, qb[0]);
                void'(qb.pop_front());
            end
            check(!(tick_a && prev_a), "R3 A two-cycle tick", 1, 0);
            check(!(tick_b && prev_b), "R3 B two-cycle tick", 1, 0);
            prev_a = tick_a;
            prev_b = tick_b;
            check(clkout_tick == (out_b_m ? tick_b : tick_a), "R5 clkout",
                  clkout_tick, out_b_m ? tick_b : tick_a);
            for (int c = 0; c < NCH; c++) begin
                logic e;
                case (code_m[c])
                    8'h01: e = ref_stb[0];
                    8'h02: e = ref_stb[1];
                    8'h03: e = ref_stb[2];
                    8'h10: e = tick_a;
                    8'h20: e = tick_b;
                    default: e = 1'b0;
                endcase
                check(chan_clk[c] == e, "R6 R7 channel", chan_clk[c], e);
            end
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) code_m[c] = 8'h00;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: reset state
        check(tick_a == 0, "R1 tick_a", tick_a, 0);
        check(tick_b == 0, "R1 tick_b", tick_b, 0);
        check(clkout_tick == 0, "R1 clkout", clkout_tick, 0);
        check(chan_clk == '0, "R1 channels", chan_clk, 0);
        mon_on = 1;

        // R1: default divide by 6 from reference A on both dividers
        for (int i = 0; i < 12; i++) pulse(4'b0001);
        drain("R1 default divide");

        // R2 R4 R5: out-of-order source codes, clkout from B
        wr_ctl(3'd4, 3'd2, 1'b1);
        wr_div(0, 2'd1, 8'd1);
        wr_div(1, 2'd0, 8'd4);
        for (int i = 0; i < 40; i++) pulse(4'b1100);
        for (int i = 0; i < 20; i++) begin pulse(4'b1100); idle(1); end
        for (int i = 0; i < 16; i++) pulse(4'b0100);
        drain("R2 R4 sources");

        // R2: largest and mid prescale codes
        wr_ctl(3'd0, 3'd0, 1'b0);
        wr_div(0, 2'd3, 8'd1);
        wr_div(1, 2'd2, 8'd0);
        for (int i = 0; i < 300; i++) pulse(4'b0001);
        drain("R2 large prescale");

        // R8: rewrite mid-period restarts the count
        wr_div(0, 2'd0, 8'd2);
        wr_div(1, 2'd0, 8'd2);
        for (int i = 0; i < 4; i++) pulse(4'b0001);
        wr_div(0, 2'd0, 8'd2);
        for (int i = 0; i < 7; i++) pulse(4'b0001);
        drain("R8 restart");

        // R9: idle source leaves the other divider running
        wr_ctl(3'd1, 3'd0, 1'b0);
        wr_div(0, 2'd0, 8'd2);
        wr_div(1, 2'd0, 8'd2);
        for (int i = 0; i < 20; i++) pulse(4'b0001);
        drain("R9 independence");

        // R4: unused source code yields no ticks
        wr_ctl(3'd3, 3'd0, 1'b1);
        for (int i = 0; i < 20; i++) pulse(4'b1111);
        drain("R4 unused code");

        // R6 R7: routing in all lanes, undefined and stop codes
        wr_route(0, 32'h2010_0300);
        wr_route(1, 32'h0055_0201);
        wr_ctl(3'd0, 3'd0, 1'b0);
        wr_div(0, 2'd0, 8'd1);
        wr_div(1, 2'd0, 8'd2);
        for (int i = 0; i < 30; i++) begin
            case (i % 5)
                0: pulse(4'b0001);
                1: pulse(4'b0010);
                2: pulse(4'b0100);
                3: pulse(4'b1000);
                default: pulse(4'b0111);
            endcase
        end
        wr_route(0, 32'h0000_0000);
        for (int i = 0; i < 10; i++) pulse(4'b0111);
        drain("R6 R7 routing");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule